// File: doc/BRIEF.md
# Processor Cycle Counter Register

This block is a 64-bit timing register for a processor core. Its lower half is a free-running unsigned count that advances once every N core clock cycles, where N is set from 1 to 16 through a 4-bit divisor code. Its upper half is an offset owned entirely by system software. The hardware never alters the offset except on an explicit write. Software uses the offset to keep per-process accounting against the shared count.

A single read port serves two views, chosen by a mode input. The system view returns the raw count with the upper 32 bits forced to zero. The process view returns the count plus the offset, truncated to 32 bits and zero-extended. A synchronous reset and a separate clear input let the core restart timing without touching the stored offset.

Top module: `cyc_count_top`

## Requirements
- R1: While reset is high and on the first cycle after it, the read port returns zero in both modes. Reset zeroes count, offset and prescaler and selects divisor code 0 (N = 1), so the count then rises by one every cycle.
- R2: With divisor code c (4 bits, N = c + 1), the count rises by exactly one on every Nth rising edge after the prescaler was last zeroed, and holds on all other edges.
- R3: The count is unsigned and wraps from all ones to zero, with no saturation and no flag.
- R4: A new divisor code takes effect at the next prescaler terminal count (including a code written on that same edge), and the prescaler restarts from zero there. Until then the old period continues.
- R5: An offset write takes effect on the next edge and leaves the count undisturbed. A read during the write cycle still shows the old offset.
- R6: Read mode 0 (system view) returns bits 63:32 as zero and bits 31:0 as the raw count.
- R7: Read mode 1 (process view) returns bits 63:32 as zero and bits 31:0 as (count + offset) mod 2^32.
- R8: Asserting clear zeroes the count and the prescaler on the next edge, takes priority over an increment, and leaves the offset unchanged.
- R9: The offset keeps its value on every edge without an offset write, however long the count runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clr_i | input | 1 | Zero the count and the prescaler |
| div_we_i | input | 1 | Load a new divisor code |
| div_val_i | input | 4 | Divisor code, N minus one |
| off_we_i | input | 1 | Load the offset field |
| off_wdata_i | input | 32 | New offset value |
| rd_mode_i | input | 1 | 0 selects the system view, 1 the process view |
| rd_data_o | output | 64 | Read result in the selected view |

## Verification
The assertions assume that every control input is a known level at each rising edge, and that an offset write and a clear may coincide, since the two act on separate state. They also assume that a divisor code may arrive at any phase of the prescaler. The stimulus changes inputs only just after a rising edge and holds them through the next one. It deliberately writes divisor codes mid-period, together with clears and offset writes, to stay inside that envelope while exercising its corners. Counter wrap is driven on a second instance built with an 8-bit count, so the rollover is reached in a few hundred cycles.

// File: rtl/cyc_count_pkg.sv
package cyc_count_pkg;
  localparam int unsigned DIV_W = 4;

  typedef enum logic {
    RD_SYS  = 1'b0,
    RD_PROC = 1'b1
  } rd_view_e;
endpackage

// File: rtl/cyc_prescaler.sv
module cyc_prescaler #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_val_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_cfg_q;
  logic [DIV_W-1:0] div_act_q;
  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] div_next;
  logic             terminal;

  function automatic logic [DIV_W-1:0] phase_step(input logic [DIV_W-1:0] p);
    return p + 1'b1;
  endfunction

  assign terminal = (phase_q == div_act_q);
  assign div_next = div_we_i ? div_val_i : div_cfg_q;
  assign tick_o   = terminal;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cfg_q <= '0;
    end else if (div_we_i) begin
      div_cfg_q <= div_val_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_act_q <= '0;
      phase_q   <= '0;
    end else if (clr_i) begin
      phase_q   <= '0;
    end else if (terminal) begin
      phase_q   <= '0;
      div_act_q <= div_next;
    end else begin
      phase_q   <= phase_step(phase_q);
    end
  end

  always_comb begin
    assert_phase_bound_R4: assert (rst || (phase_q <= div_act_q));
  end

  assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
    terminal |=> (phase_q == '0));

  assert_clear_phase_R8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (phase_q == '0));

  assert_reset_div_R1: assert property (@(posedge clk)
    rst |=> (div_act_q == '0 && phase_q == '0));
endmodule

// File: rtl/cyc_counter.sv
module cyc_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] cnt_advance(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_advance(cnt_q);
    end
  end

  assign cnt_o = cnt_q;

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !clr_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clr_i) |=> $stable(cnt_q));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !clr_i && (&cnt_q)) |=> (cnt_q == '0));

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));

  assert_reset_cnt_R1: assert property (@(posedge clk)
    rst |=> (cnt_q == '0));
endmodule

// File: rtl/cyc_offset_reg.sv
module cyc_offset_reg #(
  parameter int unsigned OFF_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [OFF_W-1:0] wdata_i,
  output logic [OFF_W-1:0] off_o
);
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q <= '0;
    end else if (we_i) begin
      off_q <= wdata_i;
    end
  end

  assign off_o = off_q;

  assert_load_R5: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (off_q == $past(wdata_i)));

  assert_keep_R9: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(off_q));

  assert_reset_off_R1: assert property (@(posedge clk)
    rst |=> (off_q == '0));
endmodule

// File: rtl/cyc_read_mux.sv
module cyc_read_mux
  import cyc_count_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic               mode_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [CNT_W-1:0]   off_i,
  output logic [2*CNT_W-1:0] data_o
);
  localparam int unsigned OUT_W = 2 * CNT_W;

  logic [CNT_W-1:0] low_sel;
  logic [CNT_W-1:0] folded;

  function automatic logic [CNT_W-1:0] fold_sum(input logic [CNT_W-1:0] c,
                                                input logic [CNT_W-1:0] o);
    return c + o;
  endfunction

  assign folded  = fold_sum(cnt_i, off_i);
  assign low_sel = (rd_view_e'(mode_i) == RD_PROC) ? folded : cnt_i;

  genvar gi;
  generate
    for (gi = 0; gi < OUT_W; gi++) begin : g_bit
      if (gi < CNT_W) begin : g_low
        assign data_o[gi] = low_sel[gi];
      end else begin : g_high
        assign data_o[gi] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/cyc_count_top.sv
module cyc_count_top
  import cyc_count_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               div_we_i,
  input  logic [DIV_W-1:0]   div_val_i,
  input  logic               off_we_i,
  input  logic [CNT_W-1:0]   off_wdata_i,
  input  logic               rd_mode_i,
  output logic [2*CNT_W-1:0] rd_data_o
);
  logic             pre_tick;
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] off_val;

  cyc_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (clr_i),
    .div_we_i  (div_we_i),
    .div_val_i (div_val_i),
    .tick_o    (pre_tick)
  );

  cyc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr_i),
    .tick_i (pre_tick),
    .cnt_o  (cnt_val)
  );

  cyc_offset_reg #(.OFF_W(CNT_W)) u_off (
    .clk     (clk),
    .rst     (rst),
    .we_i    (off_we_i),
    .wdata_i (off_wdata_i),
    .off_o   (off_val)
  );

  cyc_read_mux #(.CNT_W(CNT_W)) u_rd (
    .mode_i (rd_mode_i),
    .cnt_i  (cnt_val),
    .off_i  (off_val),
    .data_o (rd_data_o)
  );

  assert_clear_keeps_off_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !off_we_i) |=> $stable(off_val));

  assert_offwr_keeps_cnt_R5: assert property (@(posedge clk) disable iff (rst)
    (off_we_i && !clr_i && !pre_tick) |=> $stable(cnt_val));
endmodule

// File: tb/cyc_count_top_tb_top.sv
module cyc_count_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic        div_we = 1'b0;
  logic [3:0]  div_val = 4'd0;
  logic        off_we = 1'b0;
  logic [31:0] off_wdata = 32'd0;
  logic        rd_mode = 1'b0;
  logic [63:0] rd_data;
  logic [15:0] rd_narrow;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  cyc_count_top dut_i (
    .clk(clk), .rst(rst), .clr_i(clr), .div_we_i(div_we), .div_val_i(div_val),
    .off_we_i(off_we), .off_wdata_i(off_wdata), .rd_mode_i(rd_mode),
    .rd_data_o(rd_data)
  );

  cyc_count_top #(.CNT_W(8)) dut_w (
    .clk(clk), .rst(rst), .clr_i(1'b0), .div_we_i(1'b0), .div_val_i(4'd0),
    .off_we_i(1'b0), .off_wdata_i(8'd0), .rd_mode_i(1'b0),
    .rd_data_o(rd_narrow)
  );

  // {divisor code, edges after clear, expected count}
  localparam int VEC [8][3] = '{
    '{0, 10, 10}, '{1, 10, 5}, '{2, 10, 3}, '{3, 9, 2},
    '{7, 16, 2}, '{15, 47, 2}, '{15, 48, 3}, '{4, 23, 4}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic restart(input logic [3:0] code);
    rst = 1'b1; step(1);
    rst = 1'b0; div_we = 1'b1; div_val = code; step(1);
    div_we = 1'b0; clr = 1'b1; step(1);
    clr = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] base;
    // R1: reset state in both views
    step(2);
    chk("R1 reset sys", rd_data, 64'd0);
    rd_mode = 1'b1; #0.5;
    chk("R1 reset proc", rd_data, 64'd0);
    rd_mode = 1'b0;
    rst = 1'b0;
    step(1);
    chk("R1 first count", rd_data, 64'd1);
    step(254);
    chk("R3 narrow near top", {48'd0, rd_narrow}, 64'h00ff);
    step(1);
    chk("R3 narrow wrap", {48'd0, rd_narrow}, 64'h0000);
    chk("R1 count every cycle", rd_data, 64'd256);

    // R2: table of divisor codes
    for (int i = 0; i < 8; i++) begin
      restart(VEC[i][0][3:0]);
      step(VEC[i][1]);
      chk($sformatf("R2 div code %0d", VEC[i][0]), rd_data, 64'(VEC[i][2]));
    end

    // R4: divisor change mid-period takes effect at terminal count
    restart(4'd3);
    step(2);
    div_we = 1'b1; div_val = 4'd0; step(1);
    div_we = 1'b0;
    chk("R4 old period holds", rd_data, 64'd0);
    step(3);
    chk("R4 new period after terminal", rd_data, 64'd3);

    // R5/R7: offset write, old value during write cycle
    restart(4'd15);
    rd_mode = 1'b1; off_we = 1'b1; off_wdata = 32'h1234_5678; #0.5;
    chk("R5 old offset in write cycle", rd_data, 64'd0);
    step(1);
    off_we = 1'b0;
    chk("R5 new offset visible", rd_data, 64'h1234_5678);
    rd_mode = 1'b0; #0.5;
    chk("R5 count undisturbed", rd_data, 64'd0);
    // R9: offset kept over a long run
    step(40);
    base = rd_data[31:0];
    rd_mode = 1'b1; #0.5;
    chk("R9 offset held", {32'd0, rd_data[31:0] - base}, 64'h1234_5678);
    chk("R7 upper zero proc", {32'd0, rd_data[63:32]}, 64'd0);
    // R7: folded sum wraps
    off_we = 1'b1; off_wdata = 32'hffff_ffff; step(1);
    off_we = 1'b0; clr = 1'b1; step(1);
    clr = 1'b0; step(16);
    chk("R7 folded wrap", rd_data, 64'd0);
    // R6: system view raw
    rd_mode = 1'b0; #0.5;
    chk("R6 sys view raw", rd_data, 64'd1);

    // R8: clear keeps offset and beats tick
    restart(4'd0);
    step(5);
    rd_mode = 1'b1; off_we = 1'b1; off_wdata = 32'd100; step(1);
    off_we = 1'b0; clr = 1'b1; step(1);
    clr = 1'b0;
    chk("R8 clear keeps offset", rd_data, 64'd100);
    rd_mode = 1'b0; #0.5;
    chk("R8 count cleared", rd_data, 64'd0);
    step(3);
    chk("R8 restarts", rd_data, 64'd3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule